// File: doc/BRIEF.md
# Run-Time Programmable Barrett Modular Multiplier

This block multiplies two residues and returns their product reduced modulo q. The modulus can be changed at run time. Reduction follows Barrett's method: a quotient estimate is taken from the full product times a reciprocal constant m, shifted right by k. The estimate times q is subtracted from the product. Two correction subtractions then follow, and both are always evaluated, so the result lies in [0, q) and the timing does not depend on the data.

Operands enter on a valid/ready handshake and results leave on another. The pipeline is four stages deep, accepts one operand pair per cycle, and stalls as a whole when the output is held. The modulus, the constant and the shift are loaded through a write strobe. That write takes effect only while the pipeline is empty, and a busy output tells the host when it may reconfigure.

Top module: `modmul_cfg`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_valid is 0, busy is 0 and in_ready is 1.
- R2: For a valid configuration, with in_a, in_b < q, the result is (in_a * in_b) mod q. A valid configuration has 2 <= q < 2^23, k in 16..48, 2^k > q*q and m = floor(2^k / q) below 2^24.
- R3: Every result presented with out_valid is strictly below the configured q.
- R4: With out_ready held high, an operand pair accepted at a clock edge appears with out_valid on the fourth clock edge that counts from and includes the accepting edge.
- R5: With out_ready held high, in_ready stays high, so a new pair is accepted on every cycle.
- R6: While out_valid is 1 and out_ready is 0, in_ready is 0 and out_valid and out_res hold their values at the next edge.
- R7: busy is 1 whenever any pipeline stage holds a valid pair, and it returns to 0 once all results have been taken.
- R8: A configuration write is ignored when busy is 1 or when an operand pair is accepted in the same cycle. Later results still use the previous modulus.
- R9: A configuration write whose cfg_k lies outside 16..48 is ignored entirely, including its q and m.
- R10: After reset the configuration is q = 3329, m = 5039, k = 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_q | input | 24 | Modulus to load |
| cfg_m | input | 24 | Reciprocal constant floor(2^k/q) to load |
| cfg_k | input | 6 | Shift amount to load, 16..48 |
| in_valid | input | 1 | Operand pair valid |
| in_ready | output | 1 | Pipeline can accept a pair |
| in_a | input | 24 | First operand, below q |
| in_b | input | 24 | Second operand, below q |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 24 | Reduced product |
| busy | output | 1 | Pipeline holds at least one pair |

## Verification
The range property on the result is sound only if two conditions hold. Both operands must lie below q, and the loaded (q, m, k) must form a consistent Barrett triple in which m = floor(2^k/q), 2^k exceeds q squared and m fits in 24 bits. The bench draws every operand as a random value modulo the active q. It derives each m from q and k itself, and it uses only triples that meet those limits. The deliberately bad writes it makes, one while busy and one with an out-of-range shift, are the writes the block must reject, so the active triple always stays consistent.

// File: rtl/modmul_cfg.sv
module modmul_cfg #(
  parameter int W     = 24,
  parameter int KW    = 6,
  parameter int KMIN  = 16,
  parameter int KMAX  = 48,
  parameter int RST_Q = 3329,
  parameter int RST_M = 5039,
  parameter int RST_K = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [W-1:0]  cfg_q,
  input  logic [W-1:0]  cfg_m,
  input  logic [KW-1:0] cfg_k,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_a,
  input  logic [W-1:0]  in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_res,
  output logic          busy
);
  localparam int XW = 2 * W;
  localparam int PW = XW + W;
  localparam int RW = W + 2;
  localparam int NS = 4;
  localparam logic [KW-1:0] K_LO = KW'(KMIN);
  localparam logic [KW-1:0] K_HI = KW'(KMAX);

  logic [W-1:0]  q_r, m_r;
  logic [KW-1:0] k_r;
  logic [NS-1:0] vld;
  logic          adv, take_in, cfg_ok;

  logic [XW-1:0] x1;
  logic [RW-1:0] x2;
  logic [PW-1:0] xm2;
  logic [RW-1:0] t_lo, tq, r3;
  logic [RW-1:0] qe, c1, c2;
  logic [W-1:0]  y4;

  assign adv       = !vld[NS-1] || out_ready;
  assign in_ready  = adv;
  assign take_in   = in_valid && adv;
  assign busy      = |vld;
  assign out_valid = vld[NS-1];
  assign out_res   = y4;
  assign cfg_ok    = cfg_we && !busy && !take_in && cfg_k >= K_LO && cfg_k <= K_HI;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= W'(RST_Q);
      m_r <= W'(RST_M);
      k_r <= KW'(RST_K);
    end else if (cfg_ok) begin
      q_r <= cfg_q;
      m_r <= cfg_m;
      k_r <= cfg_k;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (adv) vld <= {vld[NS-2:0], in_valid};
  end

  assign t_lo = RW'(xm2 >> k_r);
  assign tq   = t_lo * RW'(q_r);
  assign qe   = RW'(q_r);
  assign c1   = (r3 >= qe) ? r3 - qe : r3;
  assign c2   = (c1 >= qe) ? c1 - qe : c1;

  always_ff @(posedge clk) begin
    if (adv) begin
      x1  <= in_a * in_b;
      xm2 <= x1 * PW'(m_r);
      x2  <= x1[RW-1:0];
      r3  <= x2 - tq;
      y4  <= W'(c2);
    end
  end
endmodule

module modmul_cfg_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_res,
  input logic         busy,
  input logic [W-1:0] q_r
);
  a_r3_below_q: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_res < q_r);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res));

  a_r7_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> busy);

  a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(q_r));

  a_r5_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> in_ready);
endmodule

bind modmul_cfg modmul_cfg_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_res(out_res),
  .busy(busy), .q_r(q_r)
);

// File: tb/modmul_cfg_bench.sv
module modmul_cfg_bench;
  localparam int W = 24, KW = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, cfg_we, in_valid, in_ready, out_valid, out_ready, busy;
  logic [W-1:0]  cfg_q, cfg_m, in_a, in_b, out_res;
  logic [KW-1:0] cfg_k;

  modmul_cfg u_modmul_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_q(cfg_q), .cfg_m(cfg_m),
    .cfg_k(cfg_k), .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a),
    .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .busy(busy)
  );

  int n_chk = 0, n_err = 0;
  longint unsigned cq = 3329;
  longint unsigned expq[$];
  bit done = 0;

  task automatic check(string tag, longint unsigned act, longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint unsigned ref_mod(longint unsigned a, longint unsigned b,
                                              longint unsigned q);
    return (a * b) % q;
  endfunction

  task automatic write_cfg(longint unsigned q, int k);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_q  = W'(q);
    cfg_m  = W'((64'd1 << k) / q);
    cfg_k  = KW'(k);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // streams n pairs; full=1 keeps both handshakes always high
  task automatic stream(int n, int rdy_pct, bit full, string tag);
    int issued = 0;
    bit held = 0;
    bit r5_bad = 0;
    logic [W-1:0] hval = '0;
    longint unsigned a, b;
    while (issued < n || expq.size() != 0 || busy) begin
      @(negedge clk);
      if (held) check({tag, " R6 hold"}, {out_valid, out_res}, {1'b1, hval});
      in_valid = full ? (issued < n) : ((issued < n) && ($urandom % 4 != 0));
      case (issued)
        0: begin a = cq - 1; b = cq - 1; end
        1: begin a = 0;      b = cq - 1; end
        2: begin a = 1;      b = cq - 1; end
        default: begin a = $urandom % cq; b = $urandom % cq; end
      endcase
      in_a = W'(a);
      in_b = W'(b);
      out_ready = full ? 1'b1 : ($urandom % 100 < rdy_pct);
      #1;
      if (full && in_valid && !in_ready) r5_bad = 1;
      held = out_valid && !out_ready;
      hval = out_res;
      if (held) check({tag, " R6 in_ready low"}, in_ready, 0);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) check({tag, " R2 spurious result"}, 1, 0);
        else begin
          check({tag, " R2 product"}, out_res, expq.pop_front());
          check({tag, " R3 below q"}, longint'(out_res) < cq, 1);
        end
      end
      if (in_valid && in_ready) begin
        expq.push_back(ref_mod(a, b, cq));
        issued++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    if (full) check({tag, " R5 ready every cycle"}, r5_bad, 0);
    check({tag, " R7 idle after drain"}, busy, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h1D2C3B4A));
    rst_n = 0; cfg_we = 0; cfg_q = '0; cfg_m = '0; cfg_k = '0;
    in_valid = 0; in_a = '0; in_b = '0; out_ready = 1;
    repeat (3) @(negedge clk);
    check("R1 in_ready in reset", in_ready, 1);
    check("R1 out_valid in reset", out_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 busy after reset", busy, 0);
    check("R1 out_valid after reset", out_valid, 0);

    // R4 latency and R10 reset config, single pair
    in_valid = 1; in_a = 24'd3000; in_b = 24'd3328; out_ready = 1;
    @(negedge clk); in_valid = 0;
    @(negedge clk);
    @(negedge clk);
    check("R4 not yet valid at edge 3", out_valid, 0);
    check("R7 busy while in flight", busy, 1);
    @(negedge clk);
    check("R4 valid at edge 4", out_valid, 1);
    check("R10 reset config result", out_res, ref_mod(3000, 3328, 3329));
    @(negedge clk);
    check("R7 busy clears", busy, 0);

    stream(200, 70, 0, "q3329k24");
    stream(100, 100, 1, "full3329");

    cq = 12289; write_cfg(cq, 28);
    stream(300, 60, 0, "q12289k28");
    cq = 8380417; write_cfg(cq, 46);
    stream(300, 75, 0, "q8380417k46");
    stream(100, 100, 1, "full8380417");
    cq = 251; write_cfg(cq, 16);
    stream(200, 50, 0, "q251k16");
    cq = 3329; write_cfg(cq, 35);
    stream(200, 80, 0, "q3329k35");

    // R8: write while busy is ignored
    @(negedge clk);
    in_valid = 1; in_a = 24'd1234; in_b = 24'd2345; out_ready = 0;
    @(negedge clk);
    in_valid = 0;
    cfg_we = 1; cfg_q = 24'd12289; cfg_m = W'((64'd1 << 28) / 12289); cfg_k = 6'd28;
    @(negedge clk);
    cfg_we = 0;
    check("R7 busy during write", busy, 1);
    out_ready = 1;
    repeat (4) @(negedge clk);
    check("R8 busy clear before check", busy, 0);
    stream(50, 90, 0, "R8 old q kept");

    // R9: out-of-range shift ignored
    @(negedge clk);
    cfg_we = 1; cfg_q = 24'd12289; cfg_m = 24'd1; cfg_k = 6'd8;
    @(negedge clk);
    cfg_we = 0;
    stream(50, 90, 0, "R9 k8 ignored");
    @(negedge clk);
    cfg_we = 1; cfg_q = 24'd12289; cfg_m = 24'd1; cfg_k = 6'd49;
    @(negedge clk);
    cfg_we = 0;
    stream(50, 90, 0, "R9 k49 ignored");

    done = 1;
    finish_run();
  end
endmodule